// File: doc/BRIEF.md
# Channel-Group Dot-Product Processing Element

This block produces one output pixel of a convolution layer. On every accepted cycle it takes a vector of input samples and a matching vector of weights, one pair per input channel lane. It multiplies each pair, reduces the products through a registered adder tree, and adds the tree sum to a running accumulator. A full 3D convolution is built one channel group at a time. The group marked as first seeds the accumulator with the output channel's bias. Later groups add to the partial sum kept from the group before, and that partial sum never leaves the block.

When the group marked as last reaches the accumulator, the block emits the finished result for one cycle. If the activation mode asked for it when that group was presented, negative results are clamped to zero. The accumulator saturates at the limits of its signed range instead of wrapping. A scheduler upstream decides which groups to stream. Pixels may follow one another with no idle cycle between them.

Top module: `conv_dot_pe`

## Requirements
- R1: For a pixel made of a single group (first and last both set), `res_data` equals `bias` plus the sum over all lanes of sample times weight.
- R2: Across several groups of one pixel, the result is the bias taken with the first group plus every group's lane sum. The `bias` value presented with any non-first group has no effect.
- R3: `res_valid` rises for exactly one cycle for each accepted group that carries `grp_last`. It is seen LANES_LOG2+2 rising edges after the edge that accepts that group, where LANES_LOG2 is ceil(log2 LANES), so 5 edges at the default of 8 lanes. At no other time is it high.
- R4: When `relu_on` is 1 with the last group, a negative result is replaced by 0 and a non-negative result passes unchanged. When `relu_on` is 0, the result passes unchanged including its sign.
- R5: After each group the accumulator saturates to 32'h7FFF_FFFF on positive overflow and to 32'h8000_0000 on negative overflow. Later groups continue from the saturated value.
- R6: While `rst_n` is low, `res_valid` is 0 and `res_data` is 0.
- R7: Cycles with `in_valid` low change neither the accumulated sum nor the outputs, whatever appears on the data, weight, bias and flag inputs.
- R8: A group flagged first discards any previous partial sum, so back-to-back pixels are independent.
- R9: Samples and weights are 8-bit two's complement per lane, with lane i at bits [8i+7:8i]. Results are 32-bit two's complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Group present on the inputs this cycle |
| grp_first | input | 1 | Group is the first of a pixel; seed with bias |
| grp_last | input | 1 | Group is the last of a pixel; emit result |
| relu_on | input | 1 | Clamp negative result (sampled with last group) |
| samples | input | LANES*DW | Packed signed input samples, lane i at [DW*i+:DW] |
| weights | input | LANES*DW | Packed signed weights, lane i at [DW*i+:DW] |
| bias | input | AW | Signed bias, used with the first group |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | AW | Signed activated result, held between strobes |

## Verification
The bench targets pixels of one group and of several groups. A design that reseeded or re-added the bias on later groups would give a wrong sum whenever the bias lines carry junk after the first group. Idle cycles loaded with junk data expose a block that accumulates when it should not. Pixels that follow each other with no gap expose one that carries an old sum into a new pixel. Results placed near both ends of the 32-bit range expose an accumulator that wraps instead of clamping. Negative and positive results with the clamp both on and off expose a swapped or missing activation. A first-seen count of edges pins the pipeline depth.

// File: rtl/conv_dot_pe.sv
module conv_dot_pe #(
  parameter int LANES = 8,
  parameter int DW    = 8,
  parameter int AW    = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic                  grp_first,
  input  logic                  grp_last,
  input  logic                  relu_on,
  input  logic [LANES*DW-1:0]   samples,
  input  logic [LANES*DW-1:0]   weights,
  input  logic [AW-1:0]         bias,
  output logic                  res_valid,
  output logic [AW-1:0]         res_data
);
  localparam int LG     = (LANES > 1) ? $clog2(LANES) : 0;
  localparam int LEAVES = 1 << LG;
  localparam int LAT    = LG + 2;

  // heap-ordered tree: node 1 is the root, leaves at LEAVES..2*LEAVES-1
  logic signed [AW-1:0] node [1:2*LEAVES-1];
  logic                 vld_p [0:LG];
  logic                 fst_p [0:LG];
  logic                 lst_p [0:LG];
  logic                 rlu_p [0:LG];
  logic [AW-1:0]        bia_p [0:LG];
  logic signed [AW-1:0] acc;

  genvar g;
  generate
    for (g = 0; g < LEAVES; g++) begin : g_leaf
      if (g < LANES) begin : g_mul
        always_ff @(posedge clk)
          node[LEAVES+g] <= AW'($signed(samples[g*DW +: DW])) * AW'($signed(weights[g*DW +: DW]));
      end else begin : g_pad
        always_ff @(posedge clk) node[LEAVES+g] <= '0;
      end
    end
    for (g = 1; g < LEAVES; g++) begin : g_add
      always_ff @(posedge clk) node[g] <= node[2*g] + node[2*g+1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k <= LG; k++) vld_p[k] <= 1'b0;
    end else begin
      vld_p[0] <= in_valid;
      for (int k = 1; k <= LG; k++) vld_p[k] <= vld_p[k-1];
    end
    fst_p[0] <= grp_first;
    lst_p[0] <= grp_last;
    rlu_p[0] <= relu_on;
    bia_p[0] <= bias;
    for (int k = 1; k <= LG; k++) begin
      fst_p[k] <= fst_p[k-1];
      lst_p[k] <= lst_p[k-1];
      rlu_p[k] <= rlu_p[k-1];
      bia_p[k] <= bia_p[k-1];
    end
  end

  logic signed [AW-1:0] seed, sum_sat;
  logic signed [AW:0]   wide;
  assign seed = fst_p[LG] ? $signed(bia_p[LG]) : acc;
  assign wide = {seed[AW-1], seed} + {node[1][AW-1], node[1]};
  assign sum_sat = (wide[AW] == wide[AW-1]) ? wide[AW-1:0] :
                   (wide[AW] ? {1'b1, {(AW-1){1'b0}}} : {1'b0, {(AW-1){1'b1}}});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc       <= '0;
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= vld_p[LG] & lst_p[LG];
      if (vld_p[LG]) begin
        acc <= sum_sat;
        if (lst_p[LG]) res_data <= (rlu_p[LG] && sum_sat[AW-1]) ? '0 : sum_sat;
      end
    end
  end

  assert_valid_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid == $past(in_valid && grp_last, LAT));
  assert_relu_nonneg_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(relu_on, LAT)) |-> !res_data[AW-1]);
  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_p[LG] |=> ($stable(acc) && $stable(res_data)));
  assert_reset_clear_R6: assert property (@(posedge clk)
    $rose(rst_n) |-> (!res_valid && res_data == '0));
endmodule

// File: tb/test_conv_dot_pe.sv
module test_conv_dot_pe;
  localparam int NL  = 8;
  localparam int LAT = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, grp_first = 1'b0, grp_last = 1'b0, relu_on = 1'b0;
  logic [NL*8-1:0] samples = '0, weights = '0;
  logic [31:0] bias = '0;
  logic res_valid;
  logic [31:0] res_data;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  string cur_req = "R1";
  logic signed [31:0] m_acc = 0;
  logic [31:0] exp_q[$];
  string req_q[$];

  always #10 clk = ~clk;

  conv_dot_pe i_conv_dot_pe (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .grp_first(grp_first),
    .grp_last(grp_last), .relu_on(relu_on), .samples(samples), .weights(weights),
    .bias(bias), .res_valid(res_valid), .res_data(res_data));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic signed [31:0] dot(logic [NL*8-1:0] s, logic [NL*8-1:0] w);
    logic signed [31:0] t = 0;
    for (int i = 0; i < NL; i++) t += 32'($signed(s[i*8 +: 8])) * 32'($signed(w[i*8 +: 8]));
    return t;
  endfunction

  function automatic logic signed [31:0] sat_add(logic signed [31:0] a, logic signed [31:0] b);
    longint r = longint'(a) + longint'(b);
    if (r > 64'sd2147483647) return 32'h7FFF_FFFF;
    if (r < -64'sd2147483648) return 32'h8000_0000;
    return r[31:0];
  endfunction

  task automatic send(logic [NL*8-1:0] s, logic [NL*8-1:0] w, logic [31:0] b,
                      bit f, bit l, bit r);
    @(negedge clk);
    in_valid = 1'b1; samples = s; weights = w; bias = b;
    grp_first = f; grp_last = l; relu_on = r;
    m_acc = sat_add(f ? $signed(b) : m_acc, dot(s, w));
    if (l) begin
      exp_q.push_back((r && m_acc < 0) ? 32'h0 : m_acc);
      req_q.push_back(cur_req);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      samples = {$urandom, $urandom}; weights = {$urandom, $urandom};
      bias = $urandom; grp_first = 1'(($urandom)); grp_last = 1'($urandom); relu_on = 1'($urandom);
    end
  endtask

  function automatic logic [NL*8-1:0] fill(logic [7:0] v);
    return {NL{v}};
  endfunction

  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R3 actual=unexpected res_valid expected=no strobe");
      end else begin
        check(req_q.pop_front(), res_data, exp_q.pop_front());
      end
    end
  end

  task automatic t_reset;
    @(negedge clk);
    check("R6", {31'b0, res_valid}, 32'h0);
    check("R6", res_data, 32'h0);
  endtask

  task automatic t_single;
    cur_req = "R1";
    send(64'h0807060504030201, fill(8'h01), 32'd100, 1, 1, 0);
    send(64'h0102030405060708, 64'h02FF02FF02FF02FF, 32'hFFFF_FFF0, 1, 1, 0);
    idle(LAT + 2);
  endtask

  task automatic t_signed;
    cur_req = "R9";
    send(fill(8'h80), fill(8'h80), 32'd0, 1, 1, 0);
    send(fill(8'h80), fill(8'h7F), 32'd5, 1, 1, 0);
    idle(LAT + 2);
  endtask

  task automatic t_multi;
    cur_req = "R2";
    send(fill(8'h03), fill(8'h04), 32'd1000, 1, 0, 0);
    send(fill(8'hFE), fill(8'h05), 32'hDEAD_BEEF, 0, 0, 0);
    send(fill(8'h07), fill(8'h07), 32'h1234_5678, 0, 1, 0);
    idle(LAT + 2);
  endtask

  task automatic t_gap;
    cur_req = "R7";
    send(fill(8'h11), fill(8'h02), 32'd7, 1, 0, 0);
    idle(3);
    send(fill(8'hF0), fill(8'h03), 32'd0, 0, 0, 0);
    idle(2);
    send(fill(8'h01), fill(8'h01), 32'd9, 0, 1, 0);
    idle(LAT + 2);
    check("R7", res_data, m_acc);
  endtask

  task automatic t_relu;
    cur_req = "R4";
    send(fill(8'hF6), fill(8'h0A), 32'd3, 1, 1, 1);
    send(fill(8'hF6), fill(8'h0A), 32'd3, 1, 1, 0);
    send(fill(8'h05), fill(8'h06), 32'hFFFF_FFFE, 1, 1, 1);
    send(fill(8'h00), fill(8'h00), 32'd0, 1, 1, 1);
    idle(LAT + 2);
  endtask

  task automatic t_sat;
    cur_req = "R5";
    send(fill(8'h7F), fill(8'h7F), 32'h7FFF_F000, 1, 0, 0);
    send(fill(8'h80), fill(8'h01), 32'd0, 0, 1, 0);
    send(fill(8'h80), fill(8'h7F), 32'h8000_1000, 1, 1, 0);
    send(fill(8'h7F), fill(8'h7F), 32'h7FFF_FFFF, 1, 1, 0);
    idle(LAT + 2);
  endtask

  task automatic t_latency;
    int n = 0;
    cur_req = "R3";
    send(fill(8'h02), fill(8'h02), 32'd1, 1, 1, 0);
    @(negedge clk);
    in_valid = 1'b0;
    n = 1;
    while (!res_valid && n < 20) begin
      @(negedge clk);
      n++;
    end
    check("R3", n, LAT);
    @(negedge clk);
    check("R3", {31'b0, res_valid}, 32'h0);
    idle(LAT + 2);
  endtask

  task automatic t_b2b;
    cur_req = "R8";
    send(fill(8'h10), fill(8'h10), 32'd50, 1, 0, 0);
    send(fill(8'h10), fill(8'h10), 32'd0, 0, 1, 0);
    send(fill(8'h01), fill(8'h02), 32'd4, 1, 1, 0);
    send(fill(8'h03), fill(8'hFD), 32'd8, 1, 0, 1);
    send(fill(8'h01), fill(8'h01), 32'd0, 0, 1, 1);
    idle(LAT + 2);
  endtask

  task automatic t_random;
    cur_req = "R1";
    for (int p = 0; p < 40; p++) begin
      int ng = 1 + ($urandom % 4);
      bit r = 1'($urandom);
      for (int gi = 0; gi < ng; gi++) begin
        send({$urandom, $urandom}, {$urandom, $urandom}, $urandom,
             gi == 0, gi == ng - 1, r);
        if ($urandom % 3 == 0) idle(1 + $urandom % 2);
      end
    end
    idle(LAT + 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_single();
    t_signed();
    t_multi();
    t_gap();
    t_relu();
    t_sat();
    t_latency();
    t_b2b();
    t_random();
    check("R3", exp_q.size(), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule